// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This block is the byte-merge datapath behind the four partial-word transfers of a little-endian 32-bit core: load-left, load-right, store-left and store-right. Each cycle it can accept one operation. The operation carries the effective byte address, the old contents of the register involved, and the aligned memory word read from that address with its two low bits cleared. The low bits of the address select a byte offset. The unit shifts the source bytes by eight times that offset. It keeps the bytes of the other operand that the shift does not cover.

For loads, the result is the new register value. It is flagged for write-back unless the destination is register 0. For stores, the result is the full word to write back to the same aligned address, which makes the store a read-modify-write. A per-byte enable marks the bytes that come from the shifted source, so a byte-writable memory or register file can write only those bytes. Results are registered and appear one clock after the valid input. Bus access, address generation and the register file lie outside the block.

Top module: `unaligned_merge`

## Requirements
- R1: Operation code 0 (load-left) with byte offset k yields the memory word shifted left by 8*(3-k). Register bytes 0 up to 2-k are kept. Offset 3 returns the memory word unchanged.
- R2: Operation code 1 (load-right) with byte offset k yields the memory word shifted right by 8*k. Register bytes 4-k up to 3 are kept. Offset 0 returns the memory word unchanged.
- R3: Operation code 2 (store-left) with byte offset k yields the register shifted right by 8*(3-k). Memory bytes k+1 up to 3 are kept. Offset 3 returns the register unchanged.
- R4: Operation code 3 (store-right) with byte offset k yields the register shifted left by 8*k. Memory bytes 0 up to k-1 are kept. Offset 0 returns the register unchanged.
- R5: Bit i of the byte-enable output is 1 exactly when result byte i (bits 8i+7:8i) comes from the shifted source. Every other byte equals the kept operand. For codes 0 and 2 the enable covers k+1 bytes; for codes 1 and 3 it covers 4-k bytes.
- R6: The address output equals the input address with bits 1:0 forced to zero.
- R7: Results and the valid output appear exactly one clock after a valid input. When the input was not valid, the valid output and both write strobes are 0.
- R8: A load whose destination index is 0 still produces a valid result, but the register-write strobe stays 0. A load to any other destination raises the register-write strobe.
- R9: A store raises the memory-write strobe and never the register-write strobe. A load never raises the memory-write strobe.
- R10: A load-right at address A, followed by a load-left at A+3 that uses the first result as its register value, assembles the little-endian word at A exactly. This holds for any starting register value.
- R11: While reset is held, the valid output and both write strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Operation code: 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| in_addr | input | 32 | Effective byte address |
| in_dst | input | 5 | Register index involved (destination for loads) |
| in_reg | input | 32 | Old register value |
| in_mem | input | 32 | Aligned memory word at the address |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Merged register value (loads) or merged memory word (stores) |
| out_be | output | 4 | Bytes taken from the shifted source |
| out_addr | output | 32 | Aligned word address |
| out_reg_we | output | 1 | Register write request |
| out_mem_we | output | 1 | Memory write request |

## Verification
The in-RTL properties check on every cycle the one-cycle latency of valid, the gating of the two write strobes by operation and destination, and address alignment. They also check that every byte outside the enable equals the kept operand, and that the enable count matches the byte offset. Those checks cannot show that the shifted bytes land in the right lanes. The vector table does that across all sixteen operation/offset pairs with distinct byte values. The directed scenarios cover the register-0 load, idle cycles, reset, and the two-step unaligned assembly across a word boundary.

// File: rtl/umrg_pkg.sv
package umrg_pkg;

   typedef enum logic [1:0] {
      MRG_LDL = 2'd0,
      MRG_LDR = 2'd1,
      MRG_STL = 2'd2,
      MRG_STR = 2'd3
   } mrg_op_e;

   function automatic logic op_is_store(mrg_op_e op);
      return op[1];
   endfunction

   function automatic logic op_is_left(mrg_op_e op);
      return (op == MRG_LDL) || (op == MRG_STL);
   endfunction

endpackage

// File: rtl/umrg_lane.sv
module umrg_lane
   import umrg_pkg::*;
#(
   parameter int NUM_BYTES = 4,
   parameter int LANE      = 0,
   localparam int OFF_W    = $clog2(NUM_BYTES),
   localparam int DATA_W   = NUM_BYTES * 8
) (
   input  mrg_op_e             op,
   input  logic [OFF_W-1:0]    off,
   input  logic [DATA_W-1:0]   src_word,
   input  logic [7:0]          keep_byte,
   output logic [7:0]          res_byte,
   output logic                take
);

   localparam int LAST = NUM_BYTES - 1;

   int         k;
   int         idx;
   logic [7:0] picked;

   always_comb begin
      k    = int'(off);
      take = 1'b0;
      idx  = 0;
      unique case (op)
         MRG_LDL: begin
            take = (LANE >= LAST - k);
            idx  = LANE + k - LAST;
         end
         MRG_LDR: begin
            take = (LANE <= LAST - k);
            idx  = LANE + k;
         end
         MRG_STL: begin
            take = (LANE <= k);
            idx  = LANE + LAST - k;
         end
         MRG_STR: begin
            take = (LANE >= k);
            idx  = LANE - k;
         end
         default: begin
            take = 1'b0;
            idx  = 0;
         end
      endcase
   end

   always_comb begin
      picked = 8'h00;
      for (int s = 0; s < NUM_BYTES; s++) begin
         if (s == idx) picked = src_word[s*8 +: 8];
      end
      res_byte = take ? picked : keep_byte;
   end

endmodule

// File: rtl/umrg_merge.sv
module umrg_merge
   import umrg_pkg::*;
#(
   parameter int NUM_BYTES = 4,
   localparam int OFF_W    = $clog2(NUM_BYTES),
   localparam int DATA_W   = NUM_BYTES * 8
) (
   input  mrg_op_e             op,
   input  logic [OFF_W-1:0]    off,
   input  logic [DATA_W-1:0]   reg_word,
   input  logic [DATA_W-1:0]   mem_word,
   output logic [DATA_W-1:0]   merged,
   output logic [NUM_BYTES-1:0] byte_en
);

   logic [DATA_W-1:0] src_word;
   logic [DATA_W-1:0] keep_word;

   always_comb begin
      if (op_is_store(op)) begin
         src_word  = reg_word;
         keep_word = mem_word;
      end else begin
         src_word  = mem_word;
         keep_word = reg_word;
      end
   end

   for (genvar j = 0; j < NUM_BYTES; j++) begin : g_lane
      umrg_lane #(
         .NUM_BYTES (NUM_BYTES),
         .LANE      (j)
      ) u_lane (
         .op        (op),
         .off       (off),
         .src_word  (src_word),
         .keep_byte (keep_word[j*8 +: 8]),
         .res_byte  (merged[j*8 +: 8]),
         .take      (byte_en[j])
      );
   end

endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge
   import umrg_pkg::*;
#(
   parameter int NUM_BYTES = 4,
   parameter int ADDR_W    = 32,
   parameter int REG_IDX_W = 5,
   localparam int OFF_W    = $clog2(NUM_BYTES),
   localparam int DATA_W   = NUM_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [1:0]            in_op,
   input  logic [ADDR_W-1:0]     in_addr,
   input  logic [REG_IDX_W-1:0]  in_dst,
   input  logic [DATA_W-1:0]     in_reg,
   input  logic [DATA_W-1:0]     in_mem,
   output logic                  out_valid,
   output logic [DATA_W-1:0]     out_data,
   output logic [NUM_BYTES-1:0]  out_be,
   output logic [ADDR_W-1:0]     out_addr,
   output logic                  out_reg_we,
   output logic                  out_mem_we
);

   if (NUM_BYTES < 2 || (NUM_BYTES & (NUM_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("unaligned_merge: NUM_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("unaligned_merge: ADDR_W must exceed the offset width");
   end
   if (REG_IDX_W < 1) begin : g_bad_idx
      $error("unaligned_merge: REG_IDX_W must be at least 1");
   end

   mrg_op_e               op;
   logic [OFF_W-1:0]      off;
   logic [DATA_W-1:0]     merged;
   logic [NUM_BYTES-1:0]  byte_en;
   logic                  is_store;

   assign op       = mrg_op_e'(in_op);
   assign off      = in_addr[OFF_W-1:0];
   assign is_store = op_is_store(op);

   umrg_merge #(
      .NUM_BYTES (NUM_BYTES)
   ) u_merge (
      .op        (op),
      .off       (off),
      .reg_word  (in_reg),
      .mem_word  (in_mem),
      .merged    (merged),
      .byte_en   (byte_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_reg_we <= 1'b0;
         out_mem_we <= 1'b0;
      end else begin
         out_valid  <= in_valid;
         out_reg_we <= in_valid && !is_store && (in_dst != '0);
         out_mem_we <= in_valid && is_store;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         out_data <= merged;
         out_be   <= byte_en;
         out_addr <= {in_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
   end

   // Checking helpers: expand the registered enables to a bit mask
   logic [DATA_W-1:0] be_mask;
   always_comb begin
      for (int i = 0; i < NUM_BYTES; i++) be_mask[i*8 +: 8] = {8{out_be[i]}};
   end

   // R7
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_reg_we && !out_mem_we));
   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_reg_we && out_mem_we));
   // R9
   store_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[1]) |=> (out_mem_we && !out_reg_we));
   // R8
   zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op[1] && in_dst == '0) |=> (out_valid && !out_reg_we));
   // R6
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_addr[ADDR_W-1:OFF_W] == $past(in_addr[ADDR_W-1:OFF_W])
                    && out_addr[OFF_W-1:0] == '0));
   // R5
   store_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[1]) |=> ((out_data & ~be_mask) == ($past(in_mem) & ~be_mask)));
   // R5
   load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op[1]) |=> ((out_data & ~be_mask) == ($past(in_reg) & ~be_mask)));
   // R5
   left_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[0] == 1'b0) |=>
         ($countones(out_be) == int'($past(in_addr[OFF_W-1:0])) + 1));
   // R5
   right_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[0] == 1'b1) |=>
         ($countones(out_be) == NUM_BYTES - int'($past(in_addr[OFF_W-1:0]))));

endmodule

// File: tb/sim_unaligned_merge.sv
`timescale 1ns/1ps
module sim_unaligned_merge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = '0;
   logic [31:0] in_addr = '0;
   logic [4:0]  in_dst = '0;
   logic [31:0] in_reg = '0;
   logic [31:0] in_mem = '0;
   logic        out_valid;
   logic [31:0] out_data;
   logic [3:0]  out_be;
   logic [31:0] out_addr;
   logic        out_reg_we;
   logic        out_mem_we;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   unaligned_merge u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_addr(in_addr), .in_dst(in_dst), .in_reg(in_reg), .in_mem(in_mem),
      .out_valid(out_valid), .out_data(out_data), .out_be(out_be),
      .out_addr(out_addr), .out_reg_we(out_reg_we), .out_mem_we(out_mem_we)
   );

   // {op, offset, expected data, expected enables}; reg AABBCCDD, mem 11223344
   localparam logic [39:0] VEC [16] = '{
      {2'd0, 2'd0, 32'h44BBCCDD, 4'b1000},
      {2'd0, 2'd1, 32'h3344CCDD, 4'b1100},
      {2'd0, 2'd2, 32'h223344DD, 4'b1110},
      {2'd0, 2'd3, 32'h11223344, 4'b1111},
      {2'd1, 2'd0, 32'h11223344, 4'b1111},
      {2'd1, 2'd1, 32'hAA112233, 4'b0111},
      {2'd1, 2'd2, 32'hAABB1122, 4'b0011},
      {2'd1, 2'd3, 32'hAABBCC11, 4'b0001},
      {2'd2, 2'd0, 32'h112233AA, 4'b0001},
      {2'd2, 2'd1, 32'h1122AABB, 4'b0011},
      {2'd2, 2'd2, 32'h11AABBCC, 4'b0111},
      {2'd2, 2'd3, 32'hAABBCCDD, 4'b1111},
      {2'd3, 2'd0, 32'hAABBCCDD, 4'b1111},
      {2'd3, 2'd1, 32'hBBCCDD44, 4'b1110},
      {2'd3, 2'd2, 32'hCCDD3344, 4'b1100},
      {2'd3, 2'd3, 32'hDD223344, 4'b1000}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at a falling edge, outputs sampled at the following falling edge
   task automatic issue(logic [1:0] op, logic [31:0] addr, logic [4:0] dst,
                        logic [31:0] rv, logic [31:0] mv);
      in_valid = 1'b1; in_op = op; in_addr = addr; in_dst = dst;
      in_reg = rv; in_mem = mv;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      // R11: outputs quiet under reset even with valid input present
      check("R11 valid", {31'd0, out_valid}, 32'd0);
      check("R11 strobes", {30'd0, out_reg_we, out_mem_we}, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 16; i++) begin
         logic [1:0] op;
         logic [1:0] off;
         logic [31:0] exp_d;
         logic [3:0] exp_b;
         {op, off, exp_d, exp_b} = VEC[i];
         issue(op, 32'h0000_0100 + 32'(off), 5'd7, 32'hAABBCCDD, 32'h11223344);
         case (op)
            2'd0: check("R1 data", out_data, exp_d);
            2'd1: check("R2 data", out_data, exp_d);
            2'd2: check("R3 data", out_data, exp_d);
            default: check("R4 data", out_data, exp_d);
         endcase
         check("R5 enables", {28'd0, out_be}, {28'd0, exp_b});
         check("R6 address", out_addr, 32'h0000_0100);
         check("R7 valid", {31'd0, out_valid}, 32'd1);
         check("R9 strobes", {30'd0, out_reg_we, out_mem_we},
               op[1] ? 32'd1 : 32'd2);
      end

      // R7: idle cycle clears valid and strobes
      @(negedge clk);
      check("R7 idle", {29'd0, out_valid, out_reg_we, out_mem_we}, 32'd0);

      // R8: load to register 0 still valid, no register write
      issue(2'd1, 32'h0000_0202, 5'd0, 32'h01234567, 32'h89ABCDEF);
      check("R8 valid", {31'd0, out_valid}, 32'd1);
      check("R8 no write", {30'd0, out_reg_we, out_mem_we}, 32'd0);
      check("R8 data", out_data, 32'h012389AB);

      // R10: unaligned word at 0x201 spanning two aligned words
      issue(2'd1, 32'h0000_0201, 5'd9, 32'hDEADBEEF, 32'h44332211);
      check("R10 first", out_data, 32'hDE443322);
      issue(2'd0, 32'h0000_0204, 5'd9, out_data, 32'h88776655);
      check("R10 assembled", out_data, 32'h55443322);
      check("R6 next word", out_addr, 32'h0000_0204);

      // R10 from a different starting register value
      issue(2'd1, 32'h0000_0203, 5'd3, 32'h00000000, 32'hF0E0D0C0);
      issue(2'd0, 32'h0000_0206, 5'd3, out_data, 32'h0A0B0C0D);
      check("R10 offset3", out_data, 32'h0B0C0DF0);

      // R11: reset again mid-run
      in_valid = 1'b1; in_op = 2'd2;
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 rerun", {29'd0, out_valid, out_reg_we, out_mem_we}, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule